// File: doc/BRIEF.md
# LCD Common-Driver Timing Generator

This block produces the full set of display timing signals for a dot-matrix LCD common driver when the driver is the timing master. Every signal comes from one counter chain that advances on a single clock enable pulsing at the oscillator rate. The signals are:

- the row shift clock;
- the frame sync pulse;
- the AC alternation signal;
- a pair of two-phase, non-overlapping column clocks for the segment drivers.

Three static straps set the behaviour. A master strap turns generation on or off. A two-bit duty strap sets the number of lines per frame. A frequency strap sets the oscillator-to-line division ratio, so the frame rate stays about the same whichever of the two nominal oscillator rates is fitted. With the master strap low, all outputs are held idle and the counters stay parked at their start point. The chip then takes its timing from outside.

Top module: `lcd_com_timing`

## Requirements
- R1: The duty strap gives the number of line periods per frame: 2'b00 gives 48, 2'b01 gives 64, 2'b10 gives 96 and 2'b11 gives 128. `frame_o` is high throughout the first line period of every frame and low in all other line periods.
- R2: One line period lasts 48 oscillator enables when `fs_sel_i`=1 and 24 when `fs_sel_i`=0. `line_clk_o` is high for the first half of each line period and low for the second half.
- R3: A 4-step phase counter advances on every oscillator enable. `col_clk1_o` is low only in step 0 and `col_clk2_o` is low only in step 2, so the two are never low at the same time.
- R4: `alt_o` toggles once per frame, in the same cycle that `frame_o` and `line_clk_o` rise to start a new frame.
- R5: With `master_i`=0, the outputs are `line_clk_o`=0, `frame_o`=0, `alt_o`=0, `col_clk1_o`=1 and `col_clk2_o`=1, and all counters are held at their start point. When `master_i` returns to 1, output starts from that start point.
- R6: While `rst_ni` is low with `master_i`=1, the outputs are `line_clk_o`=1, `frame_o`=1, `alt_o`=0, `col_clk1_o`=1 and `col_clk2_o`=1. The phase counter rests in step 1.
- R7: In a cycle where `osc_en_i` is low, no counter advances and no output changes while `master_i` stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_en_i | input | 1 | Clock enable at the oscillator rate |
| master_i | input | 1 | 1 = generate timing, 0 = hold outputs idle |
| duty_sel_i | input | 2 | Lines-per-frame select |
| fs_sel_i | input | 1 | Division select: 1 = divide by 48, 0 = divide by 24 |
| line_clk_o | output | 1 | Row shift clock |
| frame_o | output | 1 | Frame sync pulse |
| alt_o | output | 1 | AC alternation signal |
| col_clk1_o | output | 1 | Column clock, phase 1 |
| col_clk2_o | output | 1 | Column clock, phase 2 |

## Verification
The bench uses the default parameters: division ratios of 48 and 24, four phase steps, and a largest frame of 128 lines. These defaults keep the longest frame to a few thousand oscillator enables. As a result, every duty setting can run for two complete frame boundaries with either division ratio. Running the enable every cycle, every third cycle, and held low exercises the stall behaviour. A slave interval followed by a return to master checks the restart point.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int unsigned LINES_MAX = 128;

  function automatic int unsigned duty_lines(input logic [1:0] sel);
    case (sel)
      2'b00:   return 48;
      2'b01:   return 64;
      2'b10:   return 96;
      default: return 128;
    endcase
  endfunction
endpackage

// File: rtl/lcd_tg_line_div.sv
module lcd_tg_line_div #(
  parameter int unsigned DIV_FAST = 48,
  parameter int unsigned DIV_SLOW = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic fs_sel_i,
  output logic wrap_o,
  output logic first_half_o
);
  localparam int unsigned DW = $clog2(DIV_FAST);

  logic [DW-1:0] div_q, last_v, half_v;
  logic          at_last;

  assign last_v       = fs_sel_i ? DW'(DIV_FAST - 1) : DW'(DIV_SLOW - 1);
  assign half_v       = fs_sel_i ? DW'(DIV_FAST / 2) : DW'(DIV_SLOW / 2);
  assign at_last      = (div_q >= last_v);
  assign wrap_o       = run_i & tick_i & at_last;
  assign first_half_o = (div_q < half_v);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (!run_i)  div_q <= '0;
    else if (tick_i)  div_q <= at_last ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/lcd_tg_frame.sv
module lcd_tg_frame #(
  parameter int unsigned MAX_LINES = lcd_tg_pkg::LINES_MAX
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       step_i,
  input  logic [1:0] duty_sel_i,
  output logic       first_line_o,
  output logic       alt_o
);
  localparam int unsigned LW = $clog2(MAX_LINES) + 1;

  logic [LW-1:0] line_q, last_line;
  logic          alt_q, at_last;

  assign last_line    = LW'(lcd_tg_pkg::duty_lines(duty_sel_i) - 1);
  assign at_last      = (line_q >= last_line);
  assign first_line_o = (line_q == '0);
  assign alt_o        = alt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      alt_q  <= 1'b0;
    end else if (!run_i) begin
      line_q <= '0;
      alt_q  <= 1'b0;
    end else if (step_i) begin
      if (at_last) begin
        line_q <= '0;
        alt_q  <= ~alt_q;
      end else begin
        line_q <= line_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_tg_phase.sv
module lcd_tg_phase #(
  parameter int unsigned STEPS  = 4,
  parameter int unsigned LOW_A  = 0,
  parameter int unsigned LOW_B  = 2,
  parameter int unsigned REST   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic clk_a_o,
  output logic clk_b_o
);
  localparam int unsigned PW = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [PW-1:0] ph_q;

  assign clk_a_o = (ph_q != PW'(LOW_A));
  assign clk_b_o = (ph_q != PW'(LOW_B));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= PW'(REST);
    else if (!run_i) ph_q <= PW'(REST);
    else if (tick_i) ph_q <= (ph_q == PW'(STEPS - 1)) ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/lcd_com_timing.sv
module lcd_com_timing #(
  parameter int unsigned DIV_FAST  = 48,
  parameter int unsigned DIV_SLOW  = 24,
  parameter int unsigned PH_STEPS  = 4,
  parameter int unsigned MAX_LINES = lcd_tg_pkg::LINES_MAX
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_en_i,
  input  logic       master_i,
  input  logic [1:0] duty_sel_i,
  input  logic       fs_sel_i,
  output logic       line_clk_o,
  output logic       frame_o,
  output logic       alt_o,
  output logic       col_clk1_o,
  output logic       col_clk2_o
);
  logic line_wrap, first_half, first_line, alt_raw, ca, cb;

  lcd_tg_line_div #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) i_div (
    .clk_i, .rst_ni, .run_i(master_i), .tick_i(osc_en_i), .fs_sel_i,
    .wrap_o(line_wrap), .first_half_o(first_half)
  );

  lcd_tg_frame #(.MAX_LINES(MAX_LINES)) i_frame (
    .clk_i, .rst_ni, .run_i(master_i), .step_i(line_wrap), .duty_sel_i,
    .first_line_o(first_line), .alt_o(alt_raw)
  );

  lcd_tg_phase #(.STEPS(PH_STEPS), .LOW_A(0), .LOW_B(PH_STEPS / 2), .REST(1)) i_phase (
    .clk_i, .rst_ni, .run_i(master_i), .tick_i(osc_en_i),
    .clk_a_o(ca), .clk_b_o(cb)
  );

  // slave: drive idle levels
  assign line_clk_o = master_i & first_half;
  assign frame_o    = master_i & first_line;
  assign alt_o      = master_i & alt_raw;
  assign col_clk1_o = ~master_i | ca;
  assign col_clk2_o = ~master_i | cb;
endmodule

// File: rtl/lcd_com_timing_chk.sv
module lcd_com_timing_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic osc_en_i,
  input logic master_i,
  input logic line_clk_o,
  input logic frame_o,
  input logic alt_o,
  input logic col_clk1_o,
  input logic col_clk2_o
);
  assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_clk1_o | col_clk2_o));

  assert_idle_slave_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (!line_clk_o && !frame_o && !alt_o && col_clk1_o && col_clk2_o));

  assert_frame_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(frame_o) && $past(master_i)) |-> ($rose(line_clk_o) && (alt_o != $past(alt_o))));

  assert_alt_only_at_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && (alt_o != $past(alt_o))) |-> $rose(frame_o));

  assert_hold_no_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !osc_en_i) ##1 master_i |->
      $stable({line_clk_o, frame_o, alt_o, col_clk1_o, col_clk2_o}));
endmodule

bind lcd_com_timing lcd_com_timing_chk i_chk (
  .clk_i, .rst_ni, .osc_en_i, .master_i, .line_clk_o, .frame_o, .alt_o,
  .col_clk1_o, .col_clk2_o
);

// File: tb/test_lcd_com_timing.sv
module test_lcd_com_timing;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       master = 1'b1;
  logic [1:0] duty = 2'b00;
  logic       fs = 1'b1;
  logic       cl2, frm, m, c1, c2;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  lcd_com_timing i_lcd_com_timing (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc_en), .master_i(master),
    .duty_sel_i(duty), .fs_sel_i(fs), .line_clk_o(cl2), .frame_o(frm),
    .alt_o(m), .col_clk1_o(c1), .col_clk2_o(c2)
  );

  function automatic int lines_of(input logic [1:0] s);
    return (s == 2'b00) ? 48 : (s == 2'b01) ? 64 : (s == 2'b10) ? 96 : 128;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // model: raw (ungated) state after each edge
  int md = 0, ml = 0, mph = 1;
  bit mm = 0;
  logic [4:0] exp_q[$];

  always @(posedge clk) begin
    int lim;
    lim = fs ? 48 : 24;
    if (!rst_n || !master) begin
      md = 0; ml = 0; mph = 1; mm = 0;
      exp_q.delete();
    end else begin
      if (osc_en) begin
        mph = (mph + 1) % 4;
        if (md == lim - 1) begin
          md = 0;
          if (ml == lines_of(duty) - 1) begin ml = 0; mm = ~mm; end
          else ml++;
        end else md++;
      end
      exp_q.push_back({(md < lim / 2), (ml == 0), mm, (mph != 0), (mph != 2)});
    end
  end

  // monitor
  bit pcl2 = 0, pfrm = 0, armed = 0;
  int lcnt = 0;
  always @(negedge clk) begin
    logic [4:0] e;
    if (!rst_n || !master) begin
      armed = 0; lcnt = 0;
      if (rst_n && !master) begin
        chk({cl2, frm, m, c1, c2} == 5'b00011, "R5", "idle outputs",
            {cl2, frm, m, c1, c2}, 5'b00011);
      end
    end else begin
      if (exp_q.size() != 0) begin
        e = exp_q.pop_front();
        chk(cl2 == e[4], "R2", "line clock", cl2, e[4]);
        chk(frm == e[3], "R1", "frame pulse", frm, e[3]);
        chk(m == e[2], "R4", "alternation", m, e[2]);
        chk(c1 == e[1], "R3", "col clock 1", c1, e[1]);
        chk(c2 == e[0], "R3", "col clock 2", c2, e[0]);
      end
      if (frm && !pfrm) begin
        if (armed) chk(lcnt == lines_of(duty), "R1", "lines per frame", lcnt, lines_of(duty));
        armed = 1; lcnt = 1;
      end else if (cl2 && !pcl2) lcnt++;
    end
    pcl2 = cl2; pfrm = frm;
  end

  // mode 0: every cycle, 1: every third, 2: held low
  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      osc_en = (mode == 0) ? 1'b1 : (mode == 1) ? (i % 3 == 0) : 1'b0;
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; osc_en = 1'b0;
    @(negedge clk);
    // R6 reset state
    chk({cl2, frm, m, c1, c2} == 5'b11011, "R6", "reset outputs",
        {cl2, frm, m, c1, c2}, 5'b11011);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic config_run(input logic [1:0] d, input logic f, input int mode);
    int cyc;
    duty = d; fs = f;
    do_reset();
    cyc = (lines_of(d) * 2 + 2) * (f ? 48 : 24) * (mode == 1 ? 3 : 1);
    run(cyc, mode);
  endtask

  initial begin
    logic [4:0] snap;
    do_reset();
    for (int d = 0; d < 4; d++) config_run(2'(d), 1'b1, 0);
    config_run(2'b00, 1'b0, 1);
    config_run(2'b11, 1'b0, 0);
    config_run(2'b01, 1'b0, 1);

    // R7: enable held low freezes outputs
    run(37, 0);
    run(1, 2);
    @(negedge clk);
    snap = {cl2, frm, m, c1, c2};
    for (int i = 0; i < 20; i++) begin
      run(1, 2);
      @(negedge clk);
      chk({cl2, frm, m, c1, c2} == snap, "R7", "frozen outputs", {cl2, frm, m, c1, c2}, snap);
    end

    // R5: slave interval then restart from start point
    run(300, 0);
    @(posedge clk); #1; master = 1'b0;
    run(100, 0);
    @(posedge clk); #1; master = 1'b1; osc_en = 1'b0;
    @(negedge clk);
    chk({cl2, frm, m, c1, c2} == 5'b11011, "R5", "restart point",
        {cl2, frm, m, c1, c2}, 5'b11011);
    run(48 * 50, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule